// File: doc/BRIEF.md
# I2C Target Engine with Masked Address Match

This block is the target side of a two-wire serial bus. It oversamples the clock and data lines with the system clock. It finds bus Start and Stop conditions and records them in two sticky flags, so host software can tell whether the bus is busy. It shifts bytes through one internal shift register and checks each address byte against a programmable own-address. A per-bit mask chooses which address bits take part in that check, so one instance can answer a whole range of addresses. Both 7-bit and 10-bit addressing are supported, and the all-zero general call can be accepted as a match.

Received data is double-buffered: the shift register collects a byte, then copies it into a host-visible buffer and raises the interrupt. Transmit is not buffered. A host write to the data register loads the buffer and the shift register in the same cycle. The host side is a simple register port with a write strobe, a read strobe that pops the buffer, a 3-bit register index and a combinational read-data bus. The data line is open-drain, so the block drives it only through an active-high output enable that pulls the line low.

Top module: `i2c_mask_target`

## Requirements
- R1: A data-line fall while the clock line is high sets the S flag (status bit 0) and clears the P flag (status bit 1). A data-line rise while the clock is high sets P and clears S. Both flags read 0 after reset.
- R2: The data line is sampled on each clock rise, and `sda_oe` only asserts after a clock fall. When the 7-bit address (byte bits 7:1) matches, the block acknowledges by asserting `sda_oe` during the ninth clock.
- R3: An address that does not match is not acknowledged. The data bytes that follow it, up to the next Start or Stop, are ignored: no acknowledge, no buffer update, no interrupt.
- R4: Only address bits whose mask bit is 1 are compared (mask low register index 4 covers address bits 7:0, mask high register index 5 bits 1:0 covers bits 9:8). Bits with mask 0 are don't-care.
- R5: When a data byte has been shifted in while the buffer is empty, it is copied to the data register (index 0), the buffer-full flag (status bit 4) and the interrupt flag (status bit 2, output `irq`) are set, and the byte is acknowledged.
- R6: Bytes travel MSB first in both directions.
- R7: With general call enabled (index 3 bit 6), an address byte of 0x00 is acknowledged as a write and its data is received. With general call disabled, it is not acknowledged unless it matches the own-address.
- R8: If a byte completes while the buffer is still full, the overflow flag (status bit 3) is set, the byte is not acknowledged, and the buffer keeps its old value.
- R9: An address byte with bit 0 = 1 that matches selects transmit (status bit 5). A host write to index 0 loads the shift register and the buffer together. Transmission stops after a master NACK.
- R10: In 10-bit mode (index 3 bit 7), a first byte 11110·a9·a8·0 whose upper bits pass the mask is acknowledged. A match is declared only when the second byte equals address bits 7:0 under the mask. A second byte that fails is not acknowledged.
- R11: A repeated Start in the middle of a byte returns the engine to the address phase, so a following address is matched afresh.
- R12: Writing 1 to status bit 2 or 3 clears the interrupt or the overflow flag. Reading index 0 with `host_re` clears buffer-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pad, asynchronous |
| sda_oe | output | 1 | High pulls the data line low |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (pops the data buffer at index 0) |
| host_addr | input | 3 | Register index: 0 data, 1 status, 2 address low, 3 address high and mode, 4 mask low, 5 mask high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the indexed register, combinational |
| irq | output | 1 | Interrupt flag |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This makes the longest path from a line edge to a reaction, and it shows that the bus model's half-period margins survive the extra latency. The reset own-address is set to 0x2A, so 7-bit matching can be tested straight out of reset, before any configuration write. It also lets the bench show that register index 2 comes up with that value. The mask keeps its all-ones default, so the mask and 10-bit cases start from exact matching and must change the mask registers explicitly.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and helpers for the I2C target engine.
// Assumes 8-bit bus bytes and addresses of at most 10 bits.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADR_W  = 10;

    // Protocol phase of the byte engine
    typedef enum logic [2:0] {
        PH_IDLE,   // bus free or not yet seen a Start
        PH_ADR1,   // first address byte
        PH_ADR2,   // second byte of a 10-bit address
        PH_RX,     // addressed, master writes
        PH_TX,     // addressed, master reads
        PH_SKIP    // not addressed, wait for Start or Stop
    } phase_t;

    // Host register indices
    localparam logic [2:0] IX_DATA  = 3'd0;
    localparam logic [2:0] IX_STAT  = 3'd1;
    localparam logic [2:0] IX_ADRLO = 3'd2;
    localparam logic [2:0] IX_ADRHI = 3'd3;
    localparam logic [2:0] IX_MSKLO = 3'd4;
    localparam logic [2:0] IX_MSKHI = 3'd5;

    // Equality over the bits selected by m only
    function automatic logic masked_eq(input logic [ADR_W-1:0] a,
                                       input logic [ADR_W-1:0] b,
                                       input logic [ADR_W-1:0] m);
        return ((a ^ b) & m) == '0;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes the bus clock and data lines and flags clock edges and
// Start/Stop conditions as single-cycle pulses.
// Assumes STAGES >= 2 and lines that idle high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q, sda_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic scl_f, sda_f;
            if (g == 0) begin : g_first
                // First synchronizer flop takes the raw lines
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_f <= 1'b1;
                        sda_f <= 1'b1;
                    end else begin
                        scl_f <= scl_i;
                        sda_f <= sda_i;
                    end
                end
            end else begin : g_next
                // Later flops extend the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_f <= 1'b1;
                        sda_f <= 1'b1;
                    end else begin
                        scl_f <= g_stage[g-1].scl_f;
                        sda_f <= g_stage[g-1].sda_f;
                    end
                end
            end
        end
    endgenerate

    assign scl_lvl = g_stage[STAGES-1].scl_f;
    assign sda_lvl = g_stage[STAGES-1].sda_f;

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & ~sda_lvl & sda_q;
    assign stop_det  = scl_lvl & scl_q & sda_lvl & ~sda_q;

    // Edge and condition pulses never coincide (R1)
    p_events_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det}));

endmodule

// File: rtl/i2c_addr_match.sv
// Decides whether a completed address byte selects this target, and which
// phase follows. Pure combinational; evaluated when the 8th bit is in.
module i2c_addr_match
    import i2c_tgt_pkg::*;
(
    input  phase_t             phase,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic [ADR_W-1:0]   own_adr,
    input  logic [ADR_W-1:0]   adr_mask,
    input  logic               ten_bit,
    input  logic               gc_en,
    input  logic               ten_done,
    output logic               hit,
    output phase_t             nxt
);

    logic lo7_ok, hi2_ok, lo8_ok, prefix_ok, gc_ok;

    assign lo7_ok    = masked_eq({3'b0, rx_byte[7:1]}, {3'b0, own_adr[6:0]},
                                 {3'b0, adr_mask[6:0]});
    assign hi2_ok    = masked_eq({rx_byte[2:1], 8'h00}, {own_adr[9:8], 8'h00},
                                 {adr_mask[9:8], 8'h00});
    assign lo8_ok    = masked_eq({2'b0, rx_byte}, {2'b0, own_adr[7:0]},
                                 {2'b0, adr_mask[7:0]});
    assign prefix_ok = (rx_byte[7:3] == 5'b11110);
    assign gc_ok     = gc_en && (rx_byte == 8'h00);

    // Phase decision for the byte just received
    always_comb begin
        hit = 1'b0;
        nxt = PH_SKIP;
        case (phase)
            PH_ADR1: begin
                if (gc_ok) begin
                    hit = 1'b1;
                    nxt = PH_RX;
                end else if (ten_bit) begin
                    if (prefix_ok && hi2_ok && !rx_byte[0]) begin
                        hit = 1'b1;
                        nxt = PH_ADR2;
                    end else if (prefix_ok && hi2_ok && ten_done) begin
                        hit = 1'b1;
                        nxt = PH_TX;
                    end
                end else if (lo7_ok) begin
                    hit = 1'b1;
                    nxt = rx_byte[0] ? PH_TX : PH_RX;
                end
            end
            PH_ADR2: begin
                if (lo8_ok) begin
                    hit = 1'b1;
                    nxt = PH_RX;
                end
            end
            default: begin
                hit = 1'b0;
                nxt = PH_SKIP;
            end
        endcase
    end

endmodule

// File: rtl/i2c_mask_target.sv
// I2C target engine: byte/bit sequencing, acknowledge, double-buffered
// receive, write-through transmit and the host register port.
// Assumes the host loads transmit data while the bus clock is low after
// the address or previous byte, since the clock is never held.
module i2c_mask_target
    import i2c_tgt_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [ADR_W-1:0] RST_ADDR    = 10'h07F,
    parameter logic [ADR_W-1:0] RST_MASK    = 10'h3FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        host_we,
    input  logic        host_re,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        irq
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic hit;
    phase_t nxt, phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr, rx_buf;
    logic [ADR_W-1:0]  own_adr, adr_mask;
    logic ten_bit, gc_en, ten_done;
    logic s_flag, p_flag, bf, ovf, irq_f;
    logic wr_data, rd_data, wr_stat, active;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_addr_match u_match (
        .phase(phase), .rx_byte(sr), .own_adr(own_adr), .adr_mask(adr_mask),
        .ten_bit(ten_bit), .gc_en(gc_en), .ten_done(ten_done),
        .hit(hit), .nxt(nxt)
    );

    assign wr_data = host_we && (host_addr == IX_DATA);
    assign rd_data = host_re && (host_addr == IX_DATA);
    assign wr_stat = host_we && (host_addr == IX_STAT);
    assign active  = (phase != PH_IDLE) && (phase != PH_SKIP);
    assign irq     = irq_f;

    // Host configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_adr  <= RST_ADDR;
            adr_mask <= RST_MASK;
            ten_bit  <= 1'b0;
            gc_en    <= 1'b0;
        end else if (host_we) begin
            case (host_addr)
                IX_ADRLO: own_adr[7:0]  <= host_wdata;
                IX_ADRHI: begin
                    own_adr[9:8] <= host_wdata[1:0];
                    gc_en        <= host_wdata[6];
                    ten_bit      <= host_wdata[7];
                end
                IX_MSKLO: adr_mask[7:0] <= host_wdata;
                IX_MSKHI: adr_mask[9:8] <= host_wdata[1:0];
                default: ;
            endcase
        end
    end

    // Bus engine, buffers and flags; bus events override host side effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            sr       <= '0;
            rx_buf   <= '0;
            sda_oe   <= 1'b0;
            s_flag   <= 1'b0;
            p_flag   <= 1'b0;
            bf       <= 1'b0;
            ovf      <= 1'b0;
            irq_f    <= 1'b0;
            ten_done <= 1'b0;
        end else begin
            if (wr_data) begin
                rx_buf <= host_wdata;
                sr     <= host_wdata;
            end
            if (rd_data) bf <= 1'b0;
            if (wr_stat && host_wdata[2]) irq_f <= 1'b0;
            if (wr_stat && host_wdata[3]) ovf   <= 1'b0;

            if (start_det) begin
                s_flag <= 1'b1;
                p_flag <= 1'b0;
                phase  <= PH_ADR1;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                s_flag   <= 1'b0;
                p_flag   <= 1'b1;
                phase    <= PH_IDLE;
                cnt      <= '0;
                sda_oe   <= 1'b0;
                ten_done <= 1'b0;
            end else if (scl_rise && active) begin
                if (cnt < LAST_BIT) begin
                    sr  <= {sr[BYTE_W-2:0], sda_lvl};
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    if (phase == PH_TX) begin
                        if (sda_lvl) phase <= PH_SKIP;
                        else         irq_f <= 1'b1;
                    end
                end
            end else if (scl_fall) begin
                if (!active) begin
                    sda_oe <= 1'b0;
                end else if (cnt == LAST_BIT) begin
                    case (phase)
                        PH_ADR1, PH_ADR2: begin
                            sda_oe <= hit;
                            phase  <= nxt;
                            if (hit && nxt != PH_ADR2) irq_f <= 1'b1;
                            if (hit && phase == PH_ADR2) ten_done <= 1'b1;
                        end
                        PH_RX: begin
                            if (bf) begin
                                ovf    <= 1'b1;
                                sda_oe <= 1'b0;
                            end else begin
                                rx_buf <= sr;
                                bf     <= 1'b1;
                                irq_f  <= 1'b1;
                                sda_oe <= 1'b1;
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else begin
                    sda_oe <= (phase == PH_TX) ? ~sr[BYTE_W-1] : 1'b0;
                end
            end
        end
    end

    // Host read multiplexer
    always_comb begin
        case (host_addr)
            IX_DATA:  host_rdata = rx_buf;
            IX_STAT:  host_rdata = {1'b0, (phase == PH_RX) || (phase == PH_TX),
                                    phase == PH_TX, bf, ovf, irq_f, p_flag, s_flag};
            IX_ADRLO: host_rdata = own_adr[7:0];
            IX_ADRHI: host_rdata = {ten_bit, gc_en, 4'b0, own_adr[9:8]};
            IX_MSKLO: host_rdata = adr_mask[7:0];
            IX_MSKHI: host_rdata = {6'b0, adr_mask[9:8]};
            default:  host_rdata = 8'h00;
        endcase
    end

    // The line is only pulled low after a clock fall (R2)
    p_drive_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(!scl_lvl));

    // A full buffer is never overwritten by the bus (R8)
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bf && !wr_data) |=> $stable(rx_buf));

    // An overflow is never acknowledged (R8)
    p_ovf_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> !sda_oe);

    // Start and Stop flags are mutually exclusive (R1)
    p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_flag && p_flag));

    // Buffering a byte always raises the interrupt (R5)
    p_irq_with_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bf) |-> irq_f);

endmodule

// File: tb/tb_i2c_mask_target.sv
// Directed bench: a bus master model plus host register tasks.
module tb_i2c_mask_target;

    localparam int HP = 8;   // system cycles per bus half-phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, irq;
    logic       host_we = 1'b0, host_re = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00, host_rdata;
    logic       sda_bus;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_mask_target #(.SYNC_STAGES(3), .RST_ADDR(10'h02A)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n = HP);
        repeat (n) @(negedge clk);
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, input bit pop, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_re = pop;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic m_start();
        sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
    endtask

    task automatic m_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt();
        end
        sda_m = 1'b1;
    endtask

    task automatic m_ackclk(output bit acked);
        wt(); scl_m = 1'b1; wt(); acked = ~sda_bus; scl_m = 1'b0; wt();
    endtask

    task automatic m_send(input logic [7:0] b, output bit acked);
        m_bits(b);
        m_ackclk(acked);
    endtask

    task automatic m_recv(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wt(); scl_m = 1'b1; wt(); b = {b[6:0], sda_bus}; scl_m = 1'b0;
        end
        wt(); sda_m = nack; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt(); sda_m = 1'b1;
    endtask

    task automatic clr_flags();
        hw(3'd1, 8'h0C);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        hr(3'd1, 1'b0, d); chk(d == 8'h00, "R1 reset status", d, 8'h00);
        hr(3'd2, 1'b0, d); chk(d == 8'h2A, "R4 reset own address", d, 8'h2A);
        chk(sda_oe == 1'b0 && irq == 1'b0, "R2 reset outputs idle", {sda_oe, irq}, 0);
    endtask

    task automatic t_startstop();
        logic [7:0] d;
        m_start(); wt();
        hr(3'd1, 1'b0, d); chk(d[1:0] == 2'b01, "R1 start flag", d[1:0], 1);
        m_stop(); wt();
        hr(3'd1, 1'b0, d); chk(d[1:0] == 2'b10, "R1 stop flag", d[1:0], 2);
    endtask

    task automatic t_write7();
        bit a; logic [7:0] d;
        m_start();
        m_send(8'h54, a); chk(a, "R2 7-bit address ack", a, 1);
        clr_flags();
        hr(3'd1, 1'b0, d); chk(d[2] == 1'b0, "R12 irq cleared by W1C", d[2], 0);
        m_send(8'hA5, a); chk(a, "R5 data ack", a, 1);
        hr(3'd1, 1'b0, d); chk(d[4] && d[2] && irq, "R5 buffer full and irq", d, 8'h14);
        m_stop();
        hr(3'd0, 1'b1, d); chk(d == 8'hA5, "R6 received byte MSB first", d, 8'hA5);
        hr(3'd1, 1'b0, d); chk(d[4] == 1'b0, "R12 read pops buffer", d[4], 0);
        clr_flags();
    endtask

    task automatic t_nomatch();
        bit a; logic [7:0] d;
        m_start();
        m_send(8'h56, a); chk(!a, "R3 foreign address nack", a, 0);
        m_send(8'h11, a); chk(!a, "R3 data after foreign address nack", a, 0);
        m_stop();
        hr(3'd1, 1'b0, d); chk((d & 8'h14) == 8'h00, "R3 no buffer or irq", d, 0);
        hr(3'd0, 1'b0, d); chk(d == 8'hA5, "R3 buffer unchanged", d, 8'hA5);
    endtask

    task automatic t_mask();
        bit a;
        hw(3'd4, 8'h7C);
        m_start(); m_send(8'h56, a); m_stop();
        chk(a, "R4 masked-out bits ignored", a, 1);
        m_start(); m_send(8'h66, a); m_stop();
        chk(!a, "R4 compared bits still checked", a, 0);
        hw(3'd4, 8'hFF);
        clr_flags();
    endtask

    task automatic t_gc();
        bit a; logic [7:0] d;
        m_start(); m_send(8'h00, a); m_stop();
        chk(!a, "R7 general call disabled nack", a, 0);
        hw(3'd3, 8'h40);
        m_start(); m_send(8'h00, a);
        chk(a, "R7 general call enabled ack", a, 1);
        m_send(8'h99, a); m_stop();
        hr(3'd0, 1'b1, d); chk(d == 8'h99, "R7 general call data", d, 8'h99);
        hw(3'd3, 8'h00);
        clr_flags();
    endtask

    task automatic t_ovf();
        bit a1, a2, a3; logic [7:0] d;
        m_start(); m_send(8'h54, a1); m_send(8'h01, a2); m_send(8'h02, a3); m_stop();
        chk(a1 && a2 && !a3, "R8 second byte nack", {a1, a2, a3}, 3'b110);
        hr(3'd1, 1'b0, d); chk(d[3], "R8 overflow flag", d[3], 1);
        hr(3'd0, 1'b1, d); chk(d == 8'h01, "R8 buffer keeps first byte", d, 8'h01);
        clr_flags();
        hr(3'd1, 1'b0, d); chk(d[3] == 1'b0, "R12 overflow cleared by W1C", d[3], 0);
    endtask

    task automatic t_tx();
        bit a; logic [7:0] d, got;
        m_start();
        m_bits(8'h55);
        hw(3'd0, 8'hC3);
        m_ackclk(a); chk(a, "R9 read address ack", a, 1);
        hr(3'd1, 1'b0, d); chk(d[5], "R9 transmit mode", d[5], 1);
        m_recv(1'b1, got); chk(got == 8'hC3, "R6 transmitted byte MSB first", got, 8'hC3);
        m_stop();
        hr(3'd0, 1'b0, d); chk(d == 8'hC3, "R9 write reaches buffer too", d, 8'hC3);
        chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
        clr_flags();
    endtask

    task automatic t_ten();
        bit a1, a2, a3; logic [7:0] d;
        hw(3'd3, 8'h82); hw(3'd2, 8'hE5);
        m_start(); m_send(8'hF4, a1); m_send(8'hE5, a2); m_send(8'h77, a3); m_stop();
        chk(a1 && a2 && a3, "R10 10-bit match and data", {a1, a2, a3}, 3'b111);
        hr(3'd0, 1'b1, d); chk(d == 8'h77, "R10 10-bit data buffered", d, 8'h77);
        m_start(); m_send(8'hF4, a1); m_send(8'hE4, a2); m_stop();
        chk(a1 && !a2, "R10 wrong low byte nack", {a1, a2}, 2'b10);
        hw(3'd3, 8'h00); hw(3'd2, 8'h2A);
        clr_flags();
    endtask

    task automatic t_rstart();
        bit a;
        m_start();
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt();
        end
        m_start();
        m_send(8'h54, a); m_stop();
        chk(a, "R11 repeated start restarts address", a, 1);
        clr_flags();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wt(4);
        rst_n = 1'b1;
        wt(4);
        t_reset();
        t_startstop();
        t_write7();
        t_nomatch();
        t_mask();
        t_gc();
        t_ovf();
        t_tx();
        t_ten();
        t_rstart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule